// File: doc/BRIEF.md
# Double-Word Field Extract/Insert Unit

This unit pulls a bit field out of a pair of 32-bit words, or drops a field into a word. The two operands, a high word and a low word, are joined into one 64-bit value. That value is shifted left by a programmable count, and the upper half is kept as the shifter result. A programmable width then keeps only the low bits of that result.

Each operation is set by a small descriptor with three parts: an insert flag, a mask width from 0 to 32 and a shift count from 0 to 31. In extract mode the output is the masked shifter result, with every bit above the field forced to zero. In insert mode the mask also loses its lowest shift-count bits. Bits under the mask come from the shifter, and all other bits are copied from the low operand. This lets a field be written into a word that already holds other data.

The result can pass through one output register, chosen by a parameter, or leave the unit combinationally.

Top module: `fu_field_unit`

## Requirements
- R1: The shifter result equals the upper DATA_W bits of the concatenation {left_i, right_i} shifted left by shamt_i. With shamt_i = 0 it equals left_i.
- R2: The base mask has its low width_i bits set and all other bits clear. When width_i >= DATA_W it is all ones, so a full-width extract returns the shifter result unchanged.
- R3: In extract mode (insert_i = 0) the output equals the shifter result ANDed with the base mask. Every output bit at or above width_i is 0.
- R4: In insert mode (insert_i = 1) the effective mask is the base mask with its low shamt_i bits cleared. Output bits where this mask is 1 come from the shifter result, and all other output bits come from right_i.
- R5: In extract mode, width_i = 0 gives an all-zero output whatever the data and shift.
- R6: In insert mode, width_i = 0, or any width_i not larger than shamt_i, gives right_i unchanged at the output.
- R7: With OUT_REG = 1 the result appears on result_o one clock after its inputs are sampled, and the output holds its old value until that edge. With OUT_REG = 0 result_o follows the inputs in the same cycle.
- R8: With OUT_REG = 1, an active-low rst_n clears result_o to zero at once and holds it there while asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| insert_i | input | 1 | Descriptor mode: 0 extracts, 1 inserts |
| left_i | input | DATA_W | High word of the double-word operand |
| right_i | input | DATA_W | Low word of the double-word operand; also the background word for an insert |
| width_i | input | $clog2(DATA_W)+1 | Descriptor mask width, the number of low bits kept |
| shamt_i | input | $clog2(DATA_W) | Descriptor left-shift count |
| result_o | output | DATA_W | Extracted or merged word |

## Verification
The bench builds two copies of the unit. The first has DATA_W = 8 with the output register present. With an 8-bit word every combination of mode, mask width and shift count can be swept against several operand pairs. The 4-bit width input also reaches values of 9 to 15, so the widths beyond the word are covered. The second copy keeps the full 32-bit default with OUT_REG = 0. A pseudo-random stream of operands and descriptors drives it, with widths up to 39, so the 64-bit funnel and the same-cycle path are checked at full scale.

// File: rtl/fu_pkg.sv
package fu_pkg;

  typedef enum logic {
    FU_EXTRACT = 1'b0,
    FU_INSERT  = 1'b1
  } fu_mode_e;

endpackage

// File: rtl/fu_shifter.sv
module fu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  left_i,
  input  logic [DATA_W-1:0]  right_i,
  input  logic [SHIFT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  field_o
);

  // Funnel shift: upper half of {hi,lo} after a left shift.
  function automatic logic [DATA_W-1:0] funnel_hi(
    input logic [DATA_W-1:0]  hi,
    input logic [DATA_W-1:0]  lo,
    input logic [SHIFT_W-1:0] amt
  );
    logic [2*DATA_W-1:0] cat;
    cat = {hi, lo} << amt;
    return cat[2*DATA_W-1:DATA_W];
  endfunction

  assign field_o = funnel_hi(left_i, right_i, shamt_i);

endmodule

// File: rtl/fu_mask_gen.sv
module fu_mask_gen
  import fu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_W = $clog2(DATA_W),
  parameter int MASKW_W = SHIFT_W + 1
) (
  input  fu_mode_e           mode_i,
  input  logic [MASKW_W-1:0] width_i,
  input  logic [SHIFT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  base_mask_o,
  output logic [DATA_W-1:0]  eff_mask_o
);

  localparam logic [DATA_W-1:0]  ONES    = {DATA_W{1'b1}};
  localparam logic [MASKW_W-1:0] FULL_W  = MASKW_W'(DATA_W);

  // Low-ones mask of the given width, saturating at the word size.
  function automatic logic [DATA_W-1:0] low_ones(input logic [MASKW_W-1:0] n);
    if (n >= FULL_W) return ONES;
    return ~(ONES << n);
  endfunction

  // Clear the low 'amt' bits of a mask.
  function automatic logic [DATA_W-1:0] trim_low(
    input logic [DATA_W-1:0]  m,
    input logic [SHIFT_W-1:0] amt
  );
    return m & (ONES << amt);
  endfunction

  assign base_mask_o = low_ones(width_i);
  assign eff_mask_o  = (mode_i == FU_INSERT) ? trim_low(base_mask_o, shamt_i)
                                             : base_mask_o;

endmodule

// File: rtl/fu_merge.sv
module fu_merge
  import fu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fu_mode_e          mode_i,
  input  logic [DATA_W-1:0] field_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] back_i,
  output logic [DATA_W-1:0] merged_o
);

  // Per-bit select between the shifted field and a background word.
  function automatic logic [DATA_W-1:0] bit_select(
    input logic [DATA_W-1:0] m,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    return (m & a) | (~m & b);
  endfunction

  logic [DATA_W-1:0] background;
  assign background = (mode_i == FU_INSERT) ? back_i : '0;
  assign merged_o   = bit_select(mask_i, field_i, background);

endmodule

// File: rtl/fu_field_unit.sv
module fu_field_unit
  import fu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int SHIFT_W = $clog2(DATA_W),
  localparam int MASKW_W = SHIFT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insert_i,
  input  logic [DATA_W-1:0]  left_i,
  input  logic [DATA_W-1:0]  right_i,
  input  logic [MASKW_W-1:0] width_i,
  input  logic [SHIFT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  result_o
);

  fu_mode_e          mode;
  logic [DATA_W-1:0] shifted_w;
  logic [DATA_W-1:0] base_mask_w;
  logic [DATA_W-1:0] eff_mask_w;
  logic [DATA_W-1:0] merged_w;

  assign mode = insert_i ? FU_INSERT : FU_EXTRACT;

  fu_shifter #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_shifter (
    .left_i  (left_i),
    .right_i (right_i),
    .shamt_i (shamt_i),
    .field_o (shifted_w)
  );

  fu_mask_gen #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .MASKW_W(MASKW_W)) u_mask (
    .mode_i      (mode),
    .width_i     (width_i),
    .shamt_i     (shamt_i),
    .base_mask_o (base_mask_w),
    .eff_mask_o  (eff_mask_w)
  );

  fu_merge #(.DATA_W(DATA_W)) u_merge (
    .mode_i   (mode),
    .field_i  (shifted_w),
    .mask_i   (eff_mask_w),
    .back_i   (right_i),
    .merged_o (merged_w)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= merged_w;
      end
    end else begin : g_comb
      assign result_o = merged_w;
    end
  endgenerate

endmodule

// File: rtl/fu_field_checker.sv
module fu_field_checker #(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int SHIFT_W = $clog2(DATA_W),
  localparam int MASKW_W = SHIFT_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               insert_i,
  input logic [DATA_W-1:0]  left_i,
  input logic [DATA_W-1:0]  right_i,
  input logic [MASKW_W-1:0] width_i,
  input logic [SHIFT_W-1:0] shamt_i,
  input logic [DATA_W-1:0]  shifted_w,
  input logic [DATA_W-1:0]  base_mask_w,
  input logic [DATA_W-1:0]  eff_mask_w,
  input logic [DATA_W-1:0]  merged_w,
  input logic [DATA_W-1:0]  result_o
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_ZERO_SHIFT_PASSES_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shamt_i == '0) |-> (shifted_w == left_i)); // R1

  AST_FULL_WIDTH_EXTRACT: assert property (@(posedge clk) disable iff (!rst_n)
    (!insert_i && width_i >= MASKW_W'(DATA_W)) |-> (merged_w == shifted_w)); // R2

  AST_EXTRACT_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !insert_i |-> ((merged_w & ~base_mask_w) == '0)); // R3

  AST_INSERT_KEEPS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    insert_i |-> (((merged_w ^ right_i) & ~eff_mask_w) == '0)); // R4

  AST_ZERO_WIDTH_EXTRACT: assert property (@(posedge clk) disable iff (!rst_n)
    (!insert_i && width_i == '0) |-> (merged_w == '0)); // R5

  AST_ZERO_WIDTH_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (insert_i && width_i == '0) |-> (merged_w == right_i)); // R6

  generate
    if (OUT_REG) begin : g_reg_chk
      AST_OUTPUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (result_o == $past(merged_w))); // R7
    end else begin : g_comb_chk
      AST_OUTPUT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (result_o == merged_w)); // R7
    end
  endgenerate

endmodule

bind fu_field_unit fu_field_checker #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insert_i    (insert_i),
  .left_i      (left_i),
  .right_i     (right_i),
  .width_i     (width_i),
  .shamt_i     (shamt_i),
  .shifted_w   (shifted_w),
  .base_mask_w (base_mask_w),
  .eff_mask_w  (eff_mask_w),
  .merged_w    (merged_w),
  .result_o    (result_o)
);

// File: tb/fu_field_unit_bench.sv
`timescale 1ns/1ps
module fu_field_unit_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // Small registered copy: DATA_W = 8
  logic       s_ins;
  logic [7:0] s_left, s_right, s_res;
  logic [3:0] s_width;
  logic [2:0] s_shamt;

  fu_field_unit #(.DATA_W(8), .OUT_REG(1'b1)) u_fu_field_unit (
    .clk(clk), .rst_n(rst_n), .insert_i(s_ins), .left_i(s_left),
    .right_i(s_right), .width_i(s_width), .shamt_i(s_shamt), .result_o(s_res)
  );

  // Full-size combinational copy: DATA_W = 32
  logic        w_ins;
  logic [31:0] w_left, w_right, w_res;
  logic [5:0]  w_width;
  logic [4:0]  w_shamt;

  fu_field_unit #(.DATA_W(32), .OUT_REG(1'b0)) u_fu_field_unit_w32 (
    .clk(clk), .rst_n(rst_n), .insert_i(w_ins), .left_i(w_left),
    .right_i(w_right), .width_i(w_width), .shamt_i(w_shamt), .result_o(w_res)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bitwise reference: bit b of the shifter is bit (b + w - s) of {L,R}.
  function automatic logic [31:0] ref_field(input int w, input bit ins, input int width,
                                            input int s, input logic [31:0] l,
                                            input logic [31:0] r);
    logic [31:0] res = '0;
    for (int b = 0; b < w; b++) begin
      int  p  = b + w - s;
      bit  sh = (p >= w) ? l[p-w] : r[p];
      bit  m  = (b < width) && (!ins || b >= s);
      res[b] = m ? sh : (ins ? r[b] : 1'b0);
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input int w, input bit ins, input int width, input int s);
    if (width == 0)  return ins ? "R6" : "R5";
    if (ins)         return (width <= s) ? "R6" : "R4";
    if (width >= w)  return (s == 0) ? "R1" : "R2";
    return "R3";
  endfunction

  initial begin
    logic [31:0] lf = 32'h1234_5678;
    logic [7:0]  pl, pr;
    s_ins = 1'b0; s_left = 8'hA5; s_right = 8'h3C; s_width = 4'd8; s_shamt = 3'd2;
    w_ins = 1'b0; w_left = '0; w_right = '0; w_width = '0; w_shamt = '0;

    // R8: output held at zero while reset is asserted
    repeat (3) @(negedge clk);
    check("R8", {24'h0, s_res}, 32'h0);
    rst_n = 1'b1;

    // R7: one-cycle latency, output stable until the edge
    @(negedge clk);
    s_ins = 1'b0; s_left = 8'h5A; s_right = 8'h00; s_width = 4'd8; s_shamt = 3'd0;
    @(negedge clk);
    check("R7", {24'h0, s_res}, 32'h5A);
    s_left = 8'hC3;
    #1 check("R7", {24'h0, s_res}, 32'h5A);
    @(negedge clk);
    check("R7", {24'h0, s_res}, 32'hC3);

    // Exhaustive sweep of the 8-bit copy
    for (int pat = 0; pat < 4; pat++) begin
      case (pat)
        0: begin pl = 8'hA5; pr = 8'h3C; end
        1: begin pl = 8'hFF; pr = 8'h00; end
        2: begin pl = 8'h00; pr = 8'hFF; end
        default: begin pl = 8'h81; pr = 8'h7E; end
      endcase
      for (int ins = 0; ins < 2; ins++)
        for (int wd = 0; wd < 16; wd++)
          for (int sh = 0; sh < 8; sh++) begin
            s_ins = ins[0]; s_left = pl; s_right = pr;
            s_width = wd[3:0]; s_shamt = sh[2:0];
            @(negedge clk);
            check(tag_for(8, ins[0], wd, sh), {24'h0, s_res},
                  ref_field(8, ins[0], wd, sh, {24'h0, pl}, {24'h0, pr}));
          end
    end

    // R8: asynchronous reset mid-run clears the registered output
    s_ins = 1'b0; s_left = 8'hFF; s_width = 4'd8; s_shamt = 3'd0;
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R8", {24'h0, s_res}, 32'h0);
    @(negedge clk);
    check("R8", {24'h0, s_res}, 32'h0);
    rst_n = 1'b1;

    // Directed full-size corners
    @(negedge clk);
    w_ins = 1'b0; w_left = 32'hDEAD_BEEF; w_right = 32'h0123_4567; w_width = 6'd32; w_shamt = 5'd0;
    #1 check("R1", w_res, 32'hDEAD_BEEF);
    w_shamt = 5'd4;
    #1 check("R2", w_res, 32'hEADB_EEF0);
    w_width = 6'd0;
    #1 check("R5", w_res, 32'h0);
    w_ins = 1'b1; w_width = 6'd4; w_shamt = 5'd8;
    #1 check("R6", w_res, 32'h0123_4567);
    w_width = 6'd16;
    #1 check("R4", w_res, ref_field(32, 1'b1, 16, 8, 32'hDEAD_BEEF, 32'h0123_4567));

    // Pseudo-random full-size stream (R7: same-cycle path)
    for (int i = 0; i < 400; i++) begin
      int wd, sh;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      w_left = lf;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      w_right = lf;
      wd = int'(lf[7:0]) % 40;
      sh = int'(lf[12:8]);
      w_ins = lf[20];
      w_width = wd[5:0]; w_shamt = sh[4:0];
      @(negedge clk);
      check(tag_for(32, w_ins, wd, sh), w_res,
            ref_field(32, w_ins, wd, sh, w_left, w_right));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule